// File: doc/BRIEF.md
# Serial Channel Command and Register Control

This block is the control path of one channel in a multi-channel serial controller. Host byte writes and reads arrive as a strobe with a two-bit register offset. The block decodes command bytes, holds the transmit enable, the receive enable and the sticky error flags, and presents the channel status byte. It also keeps a small bank of mode registers behind an auto-advancing pointer, and it passes transmit-holding writes onto a byte stream, but only while the transmitter is ready.

A command byte has two parts. Its low nibble holds separate enable and disable bits for receive and transmit. Its high nibble holds a command code. The block drives one-cycle pulses that set or clear the channel's transmit-ready interrupt bit and clear the break-change interrupt bits in the shared interrupt register. It also drives a receive-reset pulse toward the receive FIFO. Writes to the clock-select register are accepted and have no effect. The serial shifter, the receive FIFO and the shared interrupt register are outside this block.

Top module: `uart_chan_ctrl`

## Requirements
- R1: After reset, status bits 7:2 are 0, rx_en_o is 0, all pulse outputs and tx_valid_o are 0, every mode entry is 0 and the mode pointer is 0.
- R2: In a command write (offset 2), bit 0 enables receive, bit 1 disables receive, bit 2 enables transmit and bit 3 disables transmit. They are applied in that order, so a disable bit wins over the enable bit in the same byte.
- R3: Enabling transmit sets status bit 2 (tx ready) and bit 3 (tx empty) and pulses txi_set_o. Disabling it clears both bits and pulses txi_clr_o. Both results are visible in the cycle after the write, and the two pulses never occur together.
- R4: Command code 2 (bits 7:4) clears rx_en_o and pulses rx_reset_o. It is applied after the low nibble.
- R5: Command code 3 clears status bits 2 and 3 and pulses txi_clr_o, even when bit 2 of the same byte enables transmit.
- R6: Command code 4 clears error status bits 7:4. An err_set_i bit raised in the same cycle is still recorded.
- R7: Command code 5 pulses brk_clr_o for one cycle.
- R8: Command codes 0 and 6 to 15 change no state and raise no pulse.
- R9: A read or write at offset 0 accesses the mode entry selected by the pointer. The pointer then advances and stays at the last entry. Only command code 1 returns it to 0. Entry k appears on mode_o[8k+7:8k].
- R10: A write at offset 3 raises tx_valid_o with that byte on tx_data_o in the next cycle when status bit 2 is set. Otherwise the write is dropped.
- R11: A write at offset 1 (clock select) has no effect. Reads return: the current mode entry at offset 0, status_o at offset 1, 0 at offset 2, and rx_data_i at offset 3. A read at offset 3 drives rx_pop_o in that cycle. When wr_i and rd_i are both high, only the write takes effect.
- R12: Status bit 0 follows rx_rdy_i and bit 1 follows rx_full_i. err_set_i[k] sets sticky status bit 4+k (overrun, parity, framing, break).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| rx_data_i | input | 8 | Byte at the head of the receive FIFO |
| rx_rdy_i | input | 1 | Receive FIFO not empty |
| rx_full_i | input | 1 | Receive FIFO full |
| err_set_i | input | 4 | Error event pulses: overrun, parity, framing, break |
| status_o | output | 8 | Channel status byte |
| rx_en_o | output | 1 | Receiver enabled |
| rx_reset_o | output | 1 | Receive reset pulse |
| rx_pop_o | output | 1 | Receive FIFO pop, on a read at offset 3 |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| txi_set_o | output | 1 | Set the channel's transmit-ready interrupt bit |
| txi_clr_o | output | 1 | Clear the channel's transmit-ready interrupt bit |
| brk_clr_o | output | 1 | Clear both channels' break-change interrupt bits |
| mode_o | output | 16 | Mode entries, entry 0 in the low byte |

## Verification
Two cases can land in one cycle. The first is an error event arriving from the receiver in the same cycle as a reset-error command. The bench provokes this by raising err_set_i during the command write and expects the new error bit to stay set while the older bits clear. The second is an enable bit meeting a disable bit or a transmit-reset code in the same byte. That is provoked with bytes 0x0C, 0x03 and 0x34 and judged against the bench model, in which the later action wins.

// File: rtl/uart_cc_pkg.sv
package uart_cc_pkg;

  typedef enum logic [1:0] {
    OFS_MODE = 2'd0,
    OFS_STAT = 2'd1,
    OFS_CMD  = 2'd2,
    OFS_HOLD = 2'd3
  } ofs_e;

  localparam logic [3:0] CMD_PTR_CLR = 4'd1;
  localparam logic [3:0] CMD_RX_RST  = 4'd2;
  localparam logic [3:0] CMD_TX_RST  = 4'd3;
  localparam logic [3:0] CMD_ERR_RST = 4'd4;
  localparam logic [3:0] CMD_BRK_CLR = 4'd5;

  localparam int ST_RXRDY = 0;
  localparam int ST_FULL  = 1;
  localparam int ST_TXRDY = 2;
  localparam int ST_TXEMT = 3;
  localparam int ST_ERR   = 4;

  typedef struct packed {
    logic rx_on;
    logic rx_off;
    logic tx_on;
    logic tx_off;
    logic ptr_clr;
    logic rx_rst;
    logic tx_rst;
    logic err_rst;
    logic brk_clr;
  } cmd_t;

endpackage

// File: rtl/cc_cmd_decode.sv
module cc_cmd_decode
  import uart_cc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              wr_cmd_i,
  input  logic [DATA_W-1:0] data_i,
  output cmd_t              cmd_o
);

  logic [3:0] code;
  assign code = data_i[7:4];

  always_comb begin
    cmd_o = '0;
    if (wr_cmd_i) begin
      cmd_o.rx_on  = data_i[0];
      cmd_o.rx_off = data_i[1];
      cmd_o.tx_on  = data_i[2];
      cmd_o.tx_off = data_i[3];
      unique case (code)
        CMD_PTR_CLR: cmd_o.ptr_clr = 1'b1;
        CMD_RX_RST:  cmd_o.rx_rst  = 1'b1;
        CMD_TX_RST:  cmd_o.tx_rst  = 1'b1;
        CMD_ERR_RST: cmd_o.err_rst = 1'b1;
        CMD_BRK_CLR: cmd_o.brk_clr = 1'b1;
        default: ;
      endcase
    end
  end

  if (DATA_W > 8) begin : g_wide
    logic unused_hi;
    assign unused_hi = ^data_i[DATA_W-1:8];
  end

endmodule

// File: rtl/cc_mode_ptr.sv
module cc_mode_ptr #(
  parameter int DATA_W  = 8,
  parameter int ENTRIES = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic                      rd_i,
  input  logic                      ptr_clr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic [ENTRIES*DATA_W-1:0] mode_o
);

  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [PTR_W-1:0]  ptr_q;
  logic [DATA_W-1:0] ent_q [ENTRIES];
  logic              access;

  assign access = wr_i | rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_q <= '0;
    else if (ptr_clr_i) ptr_q <= '0;
    else if (access && ptr_q != LAST) ptr_q <= ptr_q + 1'b1;
  end

  for (genvar k = 0; k < ENTRIES; k++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q[k] <= '0;
      else if (wr_i && ptr_q == PTR_W'(k)) ent_q[k] <= wdata_i;
    end
    assign mode_o[k*DATA_W +: DATA_W] = ent_q[k];
  end

  assign rdata_o = ent_q[ptr_q];

  // R9: pointer leaves entry 0 after any access, and stays inside the bank
  a_r9_ptr_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access && !ptr_clr_i) |=> ptr_q != '0);
  a_r9_ptr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= LAST);
  a_r9_ptr_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_clr_i |=> ptr_q == '0);

endmodule

// File: rtl/cc_status.sv
module cc_status
  import uart_cc_pkg::*;
#(
  parameter int ERR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmd_t             cmd_i,
  input  logic [ERR_W-1:0] err_set_i,
  output logic             tx_en_o,
  output logic             rx_en_o,
  output logic [ERR_W-1:0] err_o,
  output logic             txi_set_o,
  output logic             txi_clr_o,
  output logic             rx_reset_o,
  output logic             brk_clr_o
);

  logic tx_d, rx_d, clr_d, set_d;

  // low nibble first, then command code: later action wins
  always_comb begin
    tx_d = tx_en_o;
    if (cmd_i.tx_on)  tx_d = 1'b1;
    if (cmd_i.tx_off) tx_d = 1'b0;
    if (cmd_i.tx_rst) tx_d = 1'b0;
    rx_d = rx_en_o;
    if (cmd_i.rx_on)  rx_d = 1'b1;
    if (cmd_i.rx_off) rx_d = 1'b0;
    if (cmd_i.rx_rst) rx_d = 1'b0;
  end

  assign clr_d = cmd_i.tx_off | cmd_i.tx_rst;
  assign set_d = cmd_i.tx_on & ~clr_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_o    <= 1'b0;
      rx_en_o    <= 1'b0;
      err_o      <= '0;
      txi_set_o  <= 1'b0;
      txi_clr_o  <= 1'b0;
      rx_reset_o <= 1'b0;
      brk_clr_o  <= 1'b0;
    end else begin
      tx_en_o    <= tx_d;
      rx_en_o    <= rx_d;
      err_o      <= (cmd_i.err_rst ? '0 : err_o) | err_set_i;
      txi_set_o  <= set_d;
      txi_clr_o  <= clr_d;
      rx_reset_o <= cmd_i.rx_rst;
      brk_clr_o  <= cmd_i.brk_clr;
    end
  end

  logic unused_ptr;
  assign unused_ptr = cmd_i.ptr_clr;

  a_r2_tx_off_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.tx_off |=> !tx_en_o);
  a_r2_rx_off_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.rx_off |=> !rx_en_o);
  a_r3_pulse_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(txi_set_o && txi_clr_o));
  a_r4_rx_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.rx_rst |=> (rx_reset_o && !rx_en_o));
  a_r5_tx_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.tx_rst |=> (!tx_en_o && txi_clr_o));
  a_r6_err_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.err_rst && err_set_i == '0) |=> err_o == '0);
  a_r6_err_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_set_i != '0) |=> ((err_o & $past(err_set_i)) == $past(err_set_i)));

endmodule

// File: rtl/cc_tx_gate.sv
module cc_tx_gate #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hold_i,
  input  logic              tx_rdy_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
    end else begin
      tx_valid_o <= wr_hold_i & tx_rdy_i;
      if (wr_hold_i && tx_rdy_i) tx_data_o <= wdata_i;
    end
  end

  a_r10_only_when_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(tx_rdy_i && wr_hold_i));
  a_r10_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hold_i && !tx_rdy_i) |=> !tx_valid_o);

endmodule

// File: rtl/uart_chan_ctrl.sv
module uart_chan_ctrl
  import uart_cc_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ENTRIES = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic                      rd_i,
  input  logic [1:0]                addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  input  logic [DATA_W-1:0]         rx_data_i,
  input  logic                      rx_rdy_i,
  input  logic                      rx_full_i,
  input  logic [DATA_W-5:0]         err_set_i,
  output logic [DATA_W-1:0]         status_o,
  output logic                      rx_en_o,
  output logic                      rx_reset_o,
  output logic                      rx_pop_o,
  output logic                      tx_valid_o,
  output logic [DATA_W-1:0]         tx_data_o,
  output logic                      txi_set_o,
  output logic                      txi_clr_o,
  output logic                      brk_clr_o,
  output logic [ENTRIES*DATA_W-1:0] mode_o
);

  localparam int ERR_W = DATA_W - ST_ERR;

  ofs_e              ofs;
  logic              rd_eff;
  logic              wr_mode, rd_mode, wr_cmd, wr_hold;
  cmd_t              cmd;
  logic              tx_en;
  logic [ERR_W-1:0]  err;
  logic [DATA_W-1:0] mode_rd;

  assign ofs     = ofs_e'(addr_i);
  assign rd_eff  = rd_i & ~wr_i;
  assign wr_mode = wr_i   && ofs == OFS_MODE;
  assign rd_mode = rd_eff && ofs == OFS_MODE;
  assign wr_cmd  = wr_i   && ofs == OFS_CMD;
  assign wr_hold = wr_i   && ofs == OFS_HOLD;

  cc_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .wr_cmd_i (wr_cmd),
    .data_i   (wdata_i),
    .cmd_o    (cmd)
  );

  cc_status #(.ERR_W(ERR_W)) u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .err_set_i  (err_set_i),
    .tx_en_o    (tx_en),
    .rx_en_o    (rx_en_o),
    .err_o      (err),
    .txi_set_o  (txi_set_o),
    .txi_clr_o  (txi_clr_o),
    .rx_reset_o (rx_reset_o),
    .brk_clr_o  (brk_clr_o)
  );

  cc_mode_ptr #(.DATA_W(DATA_W), .ENTRIES(ENTRIES)) u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_mode),
    .rd_i      (rd_mode),
    .ptr_clr_i (cmd.ptr_clr),
    .wdata_i   (wdata_i),
    .rdata_o   (mode_rd),
    .mode_o    (mode_o)
  );

  cc_tx_gate #(.DATA_W(DATA_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_hold_i  (wr_hold),
    .tx_rdy_i   (tx_en),
    .wdata_i    (wdata_i),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o)
  );

  // tx ready and tx empty move together: no shifter here to hold bytes
  always_comb begin
    status_o           = '0;
    status_o[ST_RXRDY] = rx_rdy_i;
    status_o[ST_FULL]  = rx_full_i;
    status_o[ST_TXRDY] = tx_en;
    status_o[ST_TXEMT] = tx_en;
    status_o[DATA_W-1:ST_ERR] = err;
  end

  always_comb begin
    unique case (ofs)
      OFS_MODE: rdata_o = mode_rd;
      OFS_STAT: rdata_o = status_o;
      OFS_CMD:  rdata_o = '0;
      OFS_HOLD: rdata_o = rx_data_i;
      default:  rdata_o = '0;
    endcase
  end

  assign rx_pop_o = rd_eff && ofs == OFS_HOLD;

  a_r11_pop_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> (addr_i == 2'd3 && !wr_i));
  a_r3_ready_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_TXRDY] == status_o[ST_TXEMT]);
  a_r3_set_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txi_set_o |-> status_o[ST_TXRDY]);
  a_r11_csel_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd1 && err_set_i == '0) |=> $stable(status_o[DATA_W-1:2]));

endmodule

// File: tb/sim_uart_chan_ctrl.sv
`timescale 1ns/1ps
module sim_uart_chan_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0, rx_data = '0;
  logic        rx_rdy = 1'b0, rx_full = 1'b0;
  logic [3:0]  err_set = '0;
  logic [7:0]  rdata, status, tx_data;
  logic        rx_en, rx_reset, rx_pop, tx_valid, txi_set, txi_clr, brk_clr;
  logic [15:0] mode;

  int checks = 0, fails = 0;
  bit running = 1'b1;

  always #4 clk = ~clk;

  uart_chan_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_data_i(rx_data), .rx_rdy_i(rx_rdy),
    .rx_full_i(rx_full), .err_set_i(err_set), .status_o(status),
    .rx_en_o(rx_en), .rx_reset_o(rx_reset), .rx_pop_o(rx_pop),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .txi_set_o(txi_set),
    .txi_clr_o(txi_clr), .brk_clr_o(brk_clr), .mode_o(mode)
  );

  // behavioural reference
  bit       m_tx, m_rx, m_set, m_clr, m_brk, m_rxrst, m_tv;
  bit [3:0] m_err;
  bit [7:0] m_td;
  bit [7:0] m_mode [2];
  int       m_ptr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tx = 0; m_rx = 0; m_set = 0; m_clr = 0; m_brk = 0; m_rxrst = 0;
      m_tv = 0; m_err = 0; m_td = 0; m_mode[0] = 0; m_mode[1] = 0; m_ptr = 0;
    end else begin
      m_set = 0; m_clr = 0; m_brk = 0; m_rxrst = 0; m_tv = 0;
      if (wr) begin
        case (addr)
          2'd0: begin m_mode[m_ptr] = wdata; m_ptr = 1; end
          2'd2: begin
            if (wdata[0]) m_rx = 1;
            if (wdata[1]) m_rx = 0;
            if (wdata[2]) m_tx = 1;
            if (wdata[3]) m_tx = 0;
            m_clr = wdata[3];
            case (wdata[7:4])
              4'd1: m_ptr = 0;
              4'd2: begin m_rx = 0; m_rxrst = 1; end
              4'd3: begin m_tx = 0; m_clr = 1; end
              4'd4: m_err = 0;
              4'd5: m_brk = 1;
              default: ;
            endcase
            m_set = wdata[2] && !m_clr;
          end
          2'd3: if (m_tx) begin m_tv = 1; m_td = wdata; end
          default: ;
        endcase
      end else if (rd && addr == 2'd0) m_ptr = 1;
      m_err = m_err | err_set;
    end
  end

  function automatic bit [7:0] m_status();
    return {m_err, m_tx, m_tx, rx_full, rx_rdy};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (running && rst_n) begin
      chk("R3 R12 status", status, m_status());
      chk("R2 R4 rx_en", rx_en, m_rx);
      chk("R3 R5 txi_set/clr", {txi_set, txi_clr}, {m_set, m_clr});
      chk("R4 R7 pulses", {rx_reset, brk_clr}, {m_rxrst, m_brk});
      chk("R10 tx_valid", tx_valid, m_tv);
      if (m_tv) chk("R10 tx_data", tx_data, m_td);
      chk("R9 mode_o", mode, {m_mode[1], m_mode[0]});
    end
  end

  task automatic wr_op(input logic [1:0] a, input logic [7:0] d, input logic [3:0] e = 4'h0);
    @(negedge clk); wr = 1; addr = a; wdata = d; err_set = e;
    @(negedge clk); wr = 0; err_set = 0; #2;
  endtask

  task automatic rd_op(input logic [1:0] a, input logic [7:0] exp, input bit pop, input string tag);
    @(negedge clk); rd = 1; addr = a; #2;
    chk(tag, rdata, exp);
    chk({tag, " pop"}, rx_pop, pop);
    @(negedge clk); rd = 0; #2;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #2;
    // R1 reset state
    chk("R1 status", status, 8'h00);
    chk("R1 outputs", {rx_en, rx_reset, tx_valid, txi_set, txi_clr, brk_clr}, 6'h0);
    chk("R1 mode", mode, 16'h0);
    // R9 pointer walk
    wr_op(2'd0, 8'hA5);
    wr_op(2'd0, 8'h3C);
    wr_op(2'd0, 8'h77);
    chk("R9 sticks at last entry", mode, 16'h77A5);
    wr_op(2'd2, 8'h10);
    rd_op(2'd0, 8'hA5, 0, "R9 read after pointer reset");
    rd_op(2'd0, 8'h77, 0, "R9 read advances");
    // R10 dropped while disabled
    wr_op(2'd3, 8'h11);
    chk("R10 drop", tx_valid, 1'b0);
    // R3 enable tx, R10 forward
    wr_op(2'd2, 8'h04);
    chk("R3 enable", {status[3:2], txi_set}, 3'b111);
    @(negedge clk); wr = 1; addr = 2'd3; wdata = 8'h5A;
    @(negedge clk); wr = 0; #2;
    chk("R10 forward", {tx_valid, tx_data}, {1'b1, 8'h5A});
    // R2 disable wins
    wr_op(2'd2, 8'h0C);
    chk("R2 tx disable wins", {status[3:2], txi_clr, txi_set}, 4'b0010);
    // R5 reset over enable
    wr_op(2'd2, 8'h04);
    wr_op(2'd2, 8'h34);
    chk("R5 reset tx", {status[3:2], txi_clr, txi_set}, 4'b0010);
    // R2 / R4 receive
    wr_op(2'd2, 8'h01);
    chk("R2 rx on", rx_en, 1'b1);
    wr_op(2'd2, 8'h03);
    chk("R2 rx off wins", rx_en, 1'b0);
    wr_op(2'd2, 8'h01);
    wr_op(2'd2, 8'h21);
    chk("R4 reset rx", {rx_en, rx_reset}, 2'b01);
    // R12 / R6 errors
    wr_op(2'd1, 8'h00, 4'b0011);
    chk("R12 sticky err", status[7:4], 4'b0011);
    wr_op(2'd2, 8'h40, 4'b1000);
    chk("R6 coincident err survives", status[7:4], 4'b1000);
    // R7
    wr_op(2'd2, 8'h50);
    chk("R7 brk clear", brk_clr, 1'b1);
    // R8 ignored codes with state set up
    wr_op(2'd2, 8'h05);
    for (int c = 0; c < 16; c++) begin
      if (c >= 1 && c <= 5) continue;
      wr_op(2'd2, 8'(c << 4));
      chk("R8 ignored code", {status[7:2], rx_en, txi_set, txi_clr, brk_clr, rx_reset},
          {4'b1000, 2'b11, 1'b1, 4'b0000});
    end
    rd_op(2'd0, 8'h77, 0, "R8 pointer kept");
    // R11 offsets and clock-select write
    wr_op(2'd1, 8'hFF);
    chk("R11 csel ignored", {status, mode}, {8'b1000_1100, 16'h77A5});
    rx_data = 8'hC3; rx_rdy = 1; rx_full = 1;
    rd_op(2'd3, 8'hC3, 1, "R11 holding read");
    rd_op(2'd1, 8'b1000_1111, 0, "R11 R12 status read");
    rd_op(2'd2, 8'h00, 0, "R11 command read");
    @(negedge clk); wr = 1; rd = 1; addr = 2'd3; wdata = 8'h9E; #2;
    chk("R11 write over read", rx_pop, 1'b0);
    @(negedge clk); wr = 0; rd = 0; #2;
    chk("R10 forward second", {tx_valid, tx_data}, {1'b1, 8'h9E});
    repeat (2) @(negedge clk);
    running = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule